// File: doc/BRIEF.md
# Key Combination Action Detector

The block watches five input lines in the always-on clock domain: three general keys, a power button and an AC-present flag. Each line is debounced by its own counter. Four independent channels then look for a chosen combination of those debounced lines. A channel may first require a separate precondition set of lines to be held before it starts timing its trigger combination.

When a channel's trigger combination has been held for that channel's detect time, the channel fires once. Its configured actions then take effect. There are four actions: a sticky interrupt and wakeup request, a sticky battery-disable level, a sticky system reset request, and an active-low embedded-controller reset pulse. When several channels fire, their reset pulses merge into a single pulse.

Configuration and status use a flat 16-entry register file. Each write is a single-cycle strobe, and the read data is decoded combinationally from the address. Both status registers are cleared by writing one to a bit.

Top module: `keycombo_det`

## Requirements
- R1: After `rst_ni` is released, `ec_rst_no` is 1, the other action outputs are 0, and all 16 register addresses read 0.
- R2: A debounced line takes the raw level only after the raw level has differed from it for debounce-time+1 consecutive cycles. The debounce time is at address 0. A shorter glitch has no effect on any output.
- R3: A channel's trigger set (config bits [4:0]) is held when it is nonzero and every selected debounced line is 1. The channel fires once, on the (detect-time+1)-th consecutive held cycle. The detect time is at address 6+c. The channel fires again only after the combination breaks and is held anew.
- R4: With precondition enable (config bit 10) set, the trigger is timed only after the precondition set (bits [9:5]) has been held for precondition-time+1 cycles. The precondition time is at address 10+c. The precondition set must stay held. Releasing it clears the precondition.
- R5: An enabled precondition whose set shares any line with the trigger set never counts as detected, so that channel never fires.
- R6: A firing with the interrupt action (bit 11) sets bit c of the interrupt status at address 14. Writing 1 to a bit clears it. A set in the same cycle wins over the clear. `intr_o` is the OR of the status bits.
- R7: `wkup_req_o` follows a wakeup status bit at address 15 bit 0. The bit is set, from the next cycle, by any firing with the interrupt action. Writing 1 to bit 0 clears it, and a set in the same cycle wins over the clear.
- R8: A firing with battery disable (bit 12) sets `bat_dis_o`, and a firing with reset request (bit 14) sets `rst_req_o`. Both stay 1 until `rst_ni`.
- R9: A firing with the embedded-controller reset action (bit 13) drives `ec_rst_no` low from the next cycle for pulse-width cycles. The pulse width is at address 1. A later such firing reloads the width, so overlapping pulses merge into one low window that lasts from the first start to the last start plus the width.
- R10: Each action follows only its own enable bit. A channel without the interrupt bit never raises `intr_o` or `wkup_req_o`.
- R11: Configuration registers read back what was written. Channel c's configuration is at address 2+c, its detect time at 6+c and its precondition time at 10+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| keys_i | input | 5 | Raw lines, active high: bit0-2 keys, bit3 power button, bit4 AC present |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| intr_o | output | 1 | Combination interrupt |
| wkup_req_o | output | 1 | Wakeup request |
| bat_dis_o | output | 1 | Battery disable, sticky |
| rst_req_o | output | 1 | System reset request, sticky |
| ec_rst_no | output | 1 | Embedded-controller reset, active low |

## Verification
The hardest condition to reach is a merged reset pulse. A second channel has to fire while the first channel's low window is still running, and that only happens if both debounce and detect timing line up. A directed case staggers two single-key channels by three cycles and counts the low cycles, which should be 3+5. The precondition gate is also hard to reach, since it needs a held precondition followed by the trigger. Random phases use short timers and multi-cycle holds of random line patterns, so preconditions, overlaps and retriggers occur often. A bench-side cycle model follows every cycle.

// File: rtl/keycombo_pkg.sv
package keycombo_pkg;
  localparam int NIN  = 5;
  localparam int NCH  = 4;
  localparam int NACT = 4;

  localparam int ACT_INTR = 0;
  localparam int ACT_BAT  = 1;
  localparam int ACT_EC   = 2;
  localparam int ACT_RST  = 3;

  typedef struct packed {
    logic [NACT-1:0] act;
    logic            pre_en;
    logic [NIN-1:0]  pre_sel;
    logic [NIN-1:0]  trig_sel;
  } ch_cfg_t;

  localparam int CFGW = $bits(ch_cfg_t);

  localparam int A_DEB   = 0;
  localparam int A_PULSE = 1;
  localparam int A_CFG0  = 2;
  localparam int A_DET0  = A_CFG0 + NCH;
  localparam int A_PRE0  = A_DET0 + NCH;
  localparam int A_INTR  = A_PRE0 + NCH;
  localparam int A_WKUP  = A_INTR + 1;
endpackage

// File: rtl/kc_debounce.sv
module kc_debounce #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          raw_i,
  input  logic [TW-1:0] limit_i,
  output logic          stable_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (raw_i == stable_o) begin
      cnt_q <= '0;
    end else if (cnt_q >= limit_i) begin
      stable_o <= raw_i;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kc_channel.sv
module kc_channel import keycombo_pkg::*; #(
  parameter int TW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NIN-1:0] keys_i,
  input  ch_cfg_t        cfg_i,
  input  logic [TW-1:0]  det_time_i,
  input  logic [TW-1:0]  pre_time_i,
  output logic           fire_o
);
  logic [TW-1:0] pcnt_q, tcnt_q;
  logic          pdet_q, fired_q;
  logic          pre_hit, trig_hit, overlap, armed, go;

  assign pre_hit  = (cfg_i.pre_sel != '0) && ((keys_i & cfg_i.pre_sel) == cfg_i.pre_sel);
  assign trig_hit = (cfg_i.trig_sel != '0) && ((keys_i & cfg_i.trig_sel) == cfg_i.trig_sel);
  assign overlap  = |(cfg_i.pre_sel & cfg_i.trig_sel);
  assign armed    = !cfg_i.pre_en || (pdet_q && !overlap);
  assign go       = armed && trig_hit;
  assign fire_o   = go && !fired_q && (tcnt_q == det_time_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      pdet_q <= 1'b0;
    end else if (!pre_hit) begin
      pcnt_q <= '0;
      pdet_q <= 1'b0;
    end else if (!pdet_q) begin
      if (pcnt_q == pre_time_i) pdet_q <= 1'b1;
      else                      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (!go) begin
      tcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      if (tcnt_q == det_time_i) fired_q <= 1'b1;
      else                      tcnt_q  <= tcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kc_pulse.sv
module kc_pulse #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [TW-1:0] width_i,
  output logic          pulse_no
);
  logic [TW-1:0] rem_q;

  // reload on every trigger: overlapping requests stretch one window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rem_q <= '0;
    else if (trig_i)          rem_q <= width_i;
    else if (rem_q != '0)     rem_q <= rem_q - 1'b1;
  end

  assign pulse_no = (rem_q == '0);
endmodule

// File: rtl/keycombo_det.sv
module keycombo_det import keycombo_pkg::*; #(
  parameter int TW = 16,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NIN-1:0] keys_i,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           intr_o,
  output logic           wkup_req_o,
  output logic           bat_dis_o,
  output logic           rst_req_o,
  output logic           ec_rst_no
);
  logic [TW-1:0]  deb_time_q, pulse_w_q;
  ch_cfg_t        cfg_q  [NCH];
  logic [TW-1:0]  det_q  [NCH];
  logic [TW-1:0]  pre_q  [NCH];
  logic [NCH-1:0] intr_sts_q;
  logic           wkup_q, bat_q, rstreq_q;

  logic [NIN-1:0] keys_deb;
  logic [NCH-1:0] ch_fire, intr_fire, bat_fire, ec_fire, rst_fire;
  logic [NCH-1:0] intr_clr;
  logic           wkup_clr;

  for (genvar i = 0; i < NIN; i++) begin : g_deb
    kc_debounce #(.TW(TW)) u_deb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_i    (keys_i[i]),
      .limit_i  (deb_time_q),
      .stable_o (keys_deb[i])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    kc_channel #(.TW(TW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .keys_i     (keys_deb),
      .cfg_i      (cfg_q[c]),
      .det_time_i (det_q[c]),
      .pre_time_i (pre_q[c]),
      .fire_o     (ch_fire[c])
    );
    assign intr_fire[c] = ch_fire[c] & cfg_q[c].act[ACT_INTR];
    assign bat_fire[c]  = ch_fire[c] & cfg_q[c].act[ACT_BAT];
    assign ec_fire[c]   = ch_fire[c] & cfg_q[c].act[ACT_EC];
    assign rst_fire[c]  = ch_fire[c] & cfg_q[c].act[ACT_RST];
  end

  kc_pulse #(.TW(TW)) u_ec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (|ec_fire),
    .width_i  (pulse_w_q),
    .pulse_no (ec_rst_no)
  );

  assign intr_clr = (reg_we_i && reg_addr_i == AW'(A_INTR)) ? reg_wdata_i[NCH-1:0] : '0;
  assign wkup_clr = reg_we_i && reg_addr_i == AW'(A_WKUP) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deb_time_q <= '0;
      pulse_w_q  <= '0;
      for (int c = 0; c < NCH; c++) begin
        cfg_q[c] <= '0;
        det_q[c] <= '0;
        pre_q[c] <= '0;
      end
    end else if (reg_we_i) begin
      if (reg_addr_i == AW'(A_DEB))   deb_time_q <= reg_wdata_i[TW-1:0];
      if (reg_addr_i == AW'(A_PULSE)) pulse_w_q  <= reg_wdata_i[TW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr_i == AW'(A_CFG0 + c)) cfg_q[c] <= ch_cfg_t'(reg_wdata_i[CFGW-1:0]);
        if (reg_addr_i == AW'(A_DET0 + c)) det_q[c] <= reg_wdata_i[TW-1:0];
        if (reg_addr_i == AW'(A_PRE0 + c)) pre_q[c] <= reg_wdata_i[TW-1:0];
      end
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_sts_q <= '0;
      wkup_q     <= 1'b0;
      bat_q      <= 1'b0;
      rstreq_q   <= 1'b0;
    end else begin
      intr_sts_q <= (intr_sts_q & ~intr_clr) | intr_fire;
      wkup_q     <= (wkup_q & ~wkup_clr) | (|intr_fire);
      bat_q      <= bat_q | (|bat_fire);
      rstreq_q   <= rstreq_q | (|rst_fire);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(A_DEB))   reg_rdata_o = DW'(deb_time_q);
    if (reg_addr_i == AW'(A_PULSE)) reg_rdata_o = DW'(pulse_w_q);
    if (reg_addr_i == AW'(A_INTR))  reg_rdata_o = DW'(intr_sts_q);
    if (reg_addr_i == AW'(A_WKUP))  reg_rdata_o = DW'(wkup_q);
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr_i == AW'(A_CFG0 + c)) reg_rdata_o = DW'(cfg_q[c]);
      if (reg_addr_i == AW'(A_DET0 + c)) reg_rdata_o = DW'(det_q[c]);
      if (reg_addr_i == AW'(A_PRE0 + c)) reg_rdata_o = DW'(pre_q[c]);
    end
  end

  assign intr_o     = |intr_sts_q;
  assign wkup_req_o = wkup_q;
  assign bat_dis_o  = bat_q;
  assign rst_req_o  = rstreq_q;
endmodule

// File: rtl/keycombo_det_chk.sv
module keycombo_det_chk import keycombo_pkg::*; #(
  parameter int TW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           intr_o,
  input logic           wkup_req_o,
  input logic           bat_dis_o,
  input logic           rst_req_o,
  input logic           ec_rst_no,
  input logic           wkup_clr,
  input logic [TW-1:0]  pulse_w_q,
  input logic [NCH-1:0] ch_fire,
  input logic [NCH-1:0] intr_fire,
  input logic [NCH-1:0] ec_fire
);
  // R8
  bat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_dis_o |=> bat_dis_o);
  // R8
  rst_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  // R7
  wkup_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wkup_req_o) |-> $past(|intr_fire));
  // R7
  wkup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wkup_req_o && !wkup_clr) |=> wkup_req_o);
  // R6
  intr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intr_o) |-> $past(|intr_fire));
  // R9
  ec_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ec_rst_no) |-> $past(|ec_fire));
  // R9
  ec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ec_fire) && pulse_w_q != '0) |=> !ec_rst_no);
  // R3
  fire_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(ch_fire & $past(ch_fire))));
endmodule

bind keycombo_det keycombo_det_chk #(.TW(TW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .intr_o     (intr_o),
  .wkup_req_o (wkup_req_o),
  .bat_dis_o  (bat_dis_o),
  .rst_req_o  (rst_req_o),
  .ec_rst_no  (ec_rst_no),
  .wkup_clr   (wkup_clr),
  .pulse_w_q  (pulse_w_q),
  .ch_fire    (ch_fire),
  .intr_fire  (intr_fire),
  .ec_fire    (ec_fire)
);

// File: tb/keycombo_det_tb.sv
module keycombo_det_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  keys = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        intr, wkup, bat, rstreq, ecn;

  always #5 clk = ~clk;

  keycombo_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .keys_i(keys),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .intr_o(intr), .wkup_req_o(wkup), .bat_dis_o(bat), .rst_req_o(rstreq), .ec_rst_no(ecn)
  );

  int n_vec = 0, n_bad = 0;

  // reference model state
  int c_deb, c_pw;
  int c_cfg[4], c_det[4], c_pre[4];
  int m_dcnt[5];
  bit m_stab[5];
  int m_pcnt[4], m_tcnt[4];
  bit m_pdet[4], m_fired[4];
  bit [3:0] m_intr;
  bit m_wk, m_bat, m_rst;
  int m_rem;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    c_deb = 0; c_pw = 0; m_intr = '0; m_wk = 0; m_bat = 0; m_rst = 0; m_rem = 0;
    for (int i = 0; i < 5; i++) begin m_dcnt[i] = 0; m_stab[i] = 0; end
    for (int c = 0; c < 4; c++) begin
      c_cfg[c] = 0; c_det[c] = 0; c_pre[c] = 0;
      m_pcnt[c] = 0; m_tcnt[c] = 0; m_pdet[c] = 0; m_fired[c] = 0;
    end
  endfunction

  function automatic int m_read(int a);
    if (a == 0) return c_deb;
    if (a == 1) return c_pw;
    if (a >= 2 && a <= 5) return c_cfg[a-2];
    if (a >= 6 && a <= 9) return c_det[a-6];
    if (a >= 10 && a <= 13) return c_pre[a-10];
    if (a == 14) return int'(m_intr);
    return int'(m_wk);
  endfunction

  function automatic void m_advance();
    int sv = 0;
    bit [3:0] f_int = '0;
    bit f_bat = 0, f_ec = 0, f_rst = 0;
    for (int i = 0; i < 5; i++) if (m_stab[i]) sv |= (1 << i);
    for (int c = 0; c < 4; c++) begin
      int trig = c_cfg[c] & 31;
      int pre  = (c_cfg[c] >> 5) & 31;
      bit pen  = ((c_cfg[c] >> 10) & 1) != 0;
      int act  = (c_cfg[c] >> 11) & 15;
      bit ph   = (pre != 0) && ((sv & pre) == pre);
      bit th   = (trig != 0) && ((sv & trig) == trig);
      bit armed = !pen || (m_pdet[c] && ((pre & trig) == 0));
      bit go   = armed && th;
      bit fire = go && !m_fired[c] && (m_tcnt[c] == c_det[c]);
      if (fire) begin
        if (act & 1) f_int[c] = 1;
        if (act & 2) f_bat = 1;
        if (act & 4) f_ec = 1;
        if (act & 8) f_rst = 1;
      end
      if (!ph) begin m_pcnt[c] = 0; m_pdet[c] = 0; end
      else if (!m_pdet[c]) begin
        if (m_pcnt[c] == c_pre[c]) m_pdet[c] = 1; else m_pcnt[c]++;
      end
      if (!go) begin m_tcnt[c] = 0; m_fired[c] = 0; end
      else if (!m_fired[c]) begin
        if (m_tcnt[c] == c_det[c]) m_fired[c] = 1; else m_tcnt[c]++;
      end
    end
    for (int i = 0; i < 5; i++) begin
      if (keys[i] == m_stab[i]) m_dcnt[i] = 0;
      else if (m_dcnt[i] >= c_deb) begin m_stab[i] = keys[i]; m_dcnt[i] = 0; end
      else m_dcnt[i]++;
    end
    if (f_ec) m_rem = c_pw; else if (m_rem != 0) m_rem--;
    m_bat |= f_bat;
    m_rst |= f_rst;
    if (we && addr == 14) m_intr &= ~wdata[3:0];
    if (we && addr == 15 && wdata[0]) m_wk = 0;
    m_intr |= f_int;
    if (f_int != 0) m_wk = 1;
    if (we) begin
      if (addr == 0) c_deb = int'(wdata);
      if (addr == 1) c_pw = int'(wdata);
      if (addr >= 2 && addr <= 5) c_cfg[addr-2] = int'(wdata[14:0]);
      if (addr >= 6 && addr <= 9) c_det[addr-6] = int'(wdata);
      if (addr >= 10 && addr <= 13) c_pre[addr-10] = int'(wdata);
    end
  endfunction

  task automatic step();
    m_advance();
    @(posedge clk);
    @(negedge clk);
    chk("R6 intr_o", intr, (m_intr != 0));
    chk("R7 wkup_req_o", wkup, m_wk);
    chk("R8 bat_dis_o", bat, m_bat);
    chk("R8 rst_req_o", rstreq, m_rst);
    chk("R9 ec_rst_no", ecn, (m_rem == 0));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 4'(a); wdata = 16'(d);
    step();
    we = 1'b0;
  endtask

  task automatic rdchk(string tag, int a);
    addr = 4'(a);
    #1;
    chk(tag, int'(rdata), m_read(a));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; keys = '0; we = 1'b0;
    m_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int cfgw(int trig, int pre, int pen, int act);
    return trig | (pre << 5) | (pen << 10) | (act << 11);
  endfunction

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: got %0d exp %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int low;
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state
    chk("R1 ec_rst_no", ecn, 1);
    chk("R1 intr_o", intr, 0);
    chk("R1 wkup", wkup, 0);
    chk("R1 bat", bat, 0);
    chk("R1 rst_req", rstreq, 0);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); #1; chk("R1 regs", int'(rdata), 0);
    end

    // R11 map readback
    wr(0, 3);
    wr(2, cfgw(1, 0, 0, 1));
    wr(7, 2); wr(8, 2); wr(13, 7);
    for (int a = 0; a < 16; a++) rdchk("R11 readback", a);

    // R2 glitch shorter than debounce window
    keys = 5'b00001; steps(3);
    keys = 5'b00000; steps(8);
    chk("R2 glitch ignored", intr, 0);
    keys = 5'b00001; steps(8);
    chk("R2 held input fires", intr, 1);

    // R3 fire once while held
    wr(15, 1);
    steps(6);
    chk("R3 no refire", wkup, 0);
    rdchk("R6 intr status", 14);
    chk("R6 status bit0", int'(rdata), 1);
    wr(14, 1);
    rdchk("R6 cleared", 14);
    chk("R6 cleared value", int'(rdata), 0);
    keys = 5'b00000; steps(6);

    // R4 precondition gating
    wr(3, cfgw(5'b00010, 5'b01000, 1, 2));
    wr(7, 2); wr(11, 2);
    keys = 5'b00010; steps(20);
    chk("R4 no precondition", bat, 0);
    keys = 5'b00000; steps(6);
    keys = 5'b01000; steps(10);
    keys = 5'b01010; steps(20);
    chk("R4 precondition met", bat, 1);
    keys = 5'b00000; steps(10);
    chk("R8 bat sticky", bat, 1);

    // R5 overlapping precondition never counts
    do_reset();
    wr(4, cfgw(5'b10100, 5'b10000, 1, 8));
    keys = 5'b11111; steps(25);
    chk("R5 overlap blocks", rstreq, 0);

    // R10 action enables independent
    wr(5, cfgw(5'b00100, 0, 0, 2));
    keys = 5'b00000; steps(3);
    keys = 5'b00100; steps(5);
    chk("R10 bat only", bat, 1);
    chk("R10 no wakeup", wkup, 0);
    chk("R10 no intr", intr, 0);

    // R9 merged reset pulse: starts 3 cycles apart, width 5
    do_reset();
    wr(1, 5);
    wr(2, cfgw(5'b00001, 0, 0, 4));
    wr(3, cfgw(5'b00010, 0, 0, 4));
    low = 0;
    keys = 5'b00001;
    step(); if (!ecn) low++;
    step(); if (!ecn) low++;
    step(); if (!ecn) low++;
    keys = 5'b00011;
    for (int i = 0; i < 15; i++) begin step(); if (!ecn) low++; end
    chk("R9 merged low cycles", low, 3 + 5);

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      int cyc = 0;
      do_reset();
      wr(0, $urandom_range(0, 2));
      wr(1, $urandom_range(1, 6));
      for (int c = 0; c < 4; c++) begin
        int trig = $urandom_range(1, 31);
        int pre  = ($urandom_range(0, 1) != 0) ? $urandom_range(1, 31) : 0;
        int pen  = (pre != 0) ? 1 : 0;
        int act  = $urandom_range(0, 15);
        if ($urandom_range(0, 3) != 0) pre = pre & ~trig;
        if (pre == 0) pen = 0;
        if (ph < 4) act = act & 5;
        wr(2 + c, cfgw(trig, pre, pen, act));
        wr(6 + c, $urandom_range(0, 5));
        wr(10 + c, $urandom_range(0, 4));
      end
      while (cyc < 400) begin
        int hold = $urandom_range(1, 12);
        keys = 5'($urandom_range(0, 31));
        for (int h = 0; h < hold; h++) begin
          if ($urandom_range(0, 9) == 0) begin
            wr($urandom_range(14, 15), $urandom_range(0, 15));
          end else begin
            step();
          end
          cyc++;
        end
      end
      for (int a = 0; a < 16; a++) rdchk("R11 random readback", a);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule